// File: doc/BRIEF.md
# Image Row Zero-Bias Corrector

This block captures a frame from an image sensor one row at a time. Each sensor row carries 64 active 8-bit pixels followed by 2 pixels from optically covered columns. The block stores the active pixels in an on-chip frame store and keeps the covered ones in a small side register. It averages the covered pixels to get that row's dark level. It then goes back over the row and subtracts the dark level from every active pixel, clamping the result at zero.

A host controls the block over a simple memory-mapped bus with a 16-bit address and 8-bit data. Writing a command word starts a capture. A status register reports that the frame is complete. The corrected pixels can then be read back one byte at a time. The sensor side uses a valid/ready handshake, so pixels may arrive with gaps of any length.

Top module: `row_bias_corr`

## Requirements
- R1: After reset the status register (address 0x1001) reads 0, `pix_ready_o` is low and `bus_rdata_o` is 0.
- R2: A write to address 0x1000 with data bit 0 set, while the block is idle, starts a capture. `pix_ready_o` rises in the next cycle and the status register then reads 0. A write to that address with bit 0 clear has no effect.
- R3: A pixel is taken only in a cycle where `pix_valid_i` and `pix_ready_o` are both high. Each row takes exactly 66 pixels: 64 active pixels, then 2 covered pixels. `pix_ready_o` is low outside a capture.
- R4: The bias of a row is the sum of its two covered pixels divided by 2, with the remainder dropped.
- R5: The stored value of each active pixel is the captured value minus the row bias, or 0 if the bias is larger.
- R6: Each row is corrected with the bias taken from that row's own covered pixels only.
- R7: Once all 64 rows are corrected, the block returns to idle and the status register bit 0 reads 1. While a capture is running it reads 0.
- R8: A read strobe in cycle t places the addressed byte on `bus_rdata_o` in cycle t+1. In all other cycles `bus_rdata_o` is 0. Pixel (row, col) is at address row*64+col. Unmapped addresses read 0.
- R9: Bus writes to frame-store addresses are ignored. A start command written during a capture is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Sensor pixel valid |
| pix_data_i | input | 8 | Sensor pixel value |
| pix_ready_o | output | 1 | Block accepts a sensor pixel |
| bus_addr_i | input | 16 | Host address |
| bus_rd_i | input | 1 | Host read strobe |
| bus_wr_i | input | 1 | Host write strobe |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Host read data, valid the cycle after the strobe |

## Verification
A random frame uses random active and covered pixels, with random gaps in `pix_valid_i` during which garbage data is driven. This tells a correct handshake apart from one that stores data it should ignore, and checks that every row uses its own bias. A directed frame cycles rows through four cases:
- zero covered pixels, where the data must pass through unchanged;
- both covered pixels at 255, where every pixel must clamp to 0;
- an odd covered sum, where truncation decides between neighbouring results;
- a pixel exactly equal to the bias.

Bus tests cover a start command with the bit clear, a repeated start during a capture, a write to the frame store, an unmapped read, and read data returning to 0 after the strobe.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_GET  = 3'd1,
    ST_BIAS = 3'd2,
    ST_FIX  = 3'd3,
    ST_NEXT = 3'd4
  } rbc_state_e;
endpackage

// File: rtl/rbc_ctrl.sv
module rbc_ctrl
  import rbc_pkg::*;
#(
  parameter int ROWS   = 64,
  parameter int COLS   = 64,
  parameter int MASKED = 2,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = $clog2(COLS + MASKED + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          pix_valid_i,
  output logic          pix_ready_o,
  output logic          pix_fire_o,
  output rbc_state_e    state_o,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LAST_IN  = CW'(COLS + MASKED - 1);
  localparam logic [CW-1:0] LAST_FIX = CW'(COLS - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  rbc_state_e    state_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          done_q;

  assign pix_ready_o = (state_q == ST_GET);
  assign pix_fire_o  = pix_ready_o & pix_valid_i;
  assign state_o     = state_q;
  assign row_o       = row_q;
  assign col_o       = col_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          row_q <= '0;
          col_q <= '0;
          if (start_i) begin
            state_q <= ST_GET;
            done_q  <= 1'b0;
          end
        end
        ST_GET: begin
          if (pix_fire_o) begin
            col_q <= col_q + 1'b1;
            if (col_q == LAST_IN) state_q <= ST_BIAS;
          end
        end
        ST_BIAS: begin
          col_q   <= '0;
          state_q <= ST_FIX;
        end
        ST_FIX: begin
          col_q <= col_q + 1'b1;
          if (col_q == LAST_FIX) state_q <= ST_NEXT;
        end
        ST_NEXT: begin
          col_q <= '0;
          if (row_q == LAST_ROW) begin
            row_q   <= '0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            row_q   <= row_q + 1'b1;
            state_q <= ST_GET;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rbc_bias.sv
module rbc_bias #(
  parameter int W      = 8,
  parameter int MASKED = 2,
  localparam int MIW   = (MASKED > 1) ? $clog2(MASKED) : 1,
  localparam int SHIFT = $clog2(MASKED),
  localparam int SW    = W + MIW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           msk_we_i,
  input  logic [MIW-1:0] msk_idx_i,
  input  logic [W-1:0]   msk_data_i,
  input  logic           latch_i,
  input  logic [W-1:0]   pix_i,
  output logic [W-1:0]   bias_o,
  output logic [W-1:0]   fixed_o
);
  logic [W-1:0]  msk_q [MASKED];
  logic [W-1:0]  bias_q;
  logic [SW-1:0] sum;

  for (genvar g = 0; g < MASKED; g++) begin : g_msk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    msk_q[g] <= '0;
      else if (msk_we_i && msk_idx_i == MIW'(g))      msk_q[g] <= msk_data_i;
    end
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < MASKED; i++) sum = sum + SW'(msk_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bias_q <= '0;
    else if (latch_i) bias_q <= W'(sum >> SHIFT);
  end

  assign bias_o  = bias_q;
  // clamp at zero rather than wrap
  assign fixed_o = (pix_i > bias_q) ? (pix_i - bias_q) : '0;
endmodule

// File: rtl/rbc_frame_mem.sv
module rbc_frame_mem #(
  parameter int W     = 8,
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [W-1:0]  rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/rbc_bus.sv
module rbc_bus #(
  parameter int          ADDR_W    = 16,
  parameter int          W         = 8,
  parameter int          DEPTH     = 4096,
  parameter logic [15:0] CMD_ADDR  = 16'h1000,
  parameter logic [15:0] STAT_ADDR = 16'h1001,
  localparam int         AW        = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              idle_i,
  input  logic              done_i,
  input  logic [W-1:0]      mem_rdata_i,
  output logic [AW-1:0]     mem_raddr_o,
  output logic              start_o,
  output logic [W-1:0]      rdata_o
);
  logic         in_pix;
  logic         hit_cmd;
  logic         hit_stat;
  logic [W-1:0] rdata_q;

  assign in_pix      = (addr_i < ADDR_W'(DEPTH));
  assign hit_cmd     = (addr_i == ADDR_W'(CMD_ADDR));
  assign hit_stat    = (addr_i == ADDR_W'(STAT_ADDR));
  assign mem_raddr_o = addr_i[AW-1:0];
  assign start_o     = wr_i & hit_cmd & wdata_i[0] & idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (!rd_i)          rdata_q <= '0;
    else if (in_pix)         rdata_q <= mem_rdata_i;
    else if (hit_stat)       rdata_q <= {{(W-1){1'b0}}, done_i};
    else                     rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/row_bias_corr.sv
module row_bias_corr
  import rbc_pkg::*;
#(
  parameter int          ROWS      = 64,
  parameter int          COLS      = 64,
  parameter int          MASKED    = 2,
  parameter int          W         = 8,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] CMD_ADDR  = 16'h1000,
  parameter logic [15:0] STAT_ADDR = 16'h1001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_valid_i,
  input  logic [W-1:0]      pix_data_i,
  output logic              pix_ready_o,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o
);
  localparam int DEPTH = ROWS * COLS;
  localparam int AW    = $clog2(DEPTH);
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW    = $clog2(COLS + MASKED + 1);
  localparam int MIW   = (MASKED > 1) ? $clog2(MASKED) : 1;

  rbc_state_e    state;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic          pix_fire;
  logic          done;
  logic          start;
  logic          col_active;
  logic [AW-1:0] cell_idx;
  logic          mem_we;
  logic [W-1:0]  mem_wdata;
  logic [W-1:0]  fix_rdata;
  logic [AW-1:0] host_raddr;
  logic [W-1:0]  host_rdata;
  logic [W-1:0]  bias;
  logic [W-1:0]  fixed_pix;
  logic          msk_we;
  logic [MIW-1:0] msk_idx;
  logic [CW-1:0] msk_off;

  rbc_ctrl #(.ROWS(ROWS), .COLS(COLS), .MASKED(MASKED)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .pix_valid_i (pix_valid_i),
    .pix_ready_o (pix_ready_o),
    .pix_fire_o  (pix_fire),
    .state_o     (state),
    .row_o       (row),
    .col_o       (col),
    .done_o      (done)
  );

  assign col_active = (col < CW'(COLS));
  assign cell_idx   = AW'(row) * AW'(COLS) + AW'(col);
  assign mem_we     = (pix_fire & col_active) | (state == ST_FIX);
  assign mem_wdata  = (state == ST_FIX) ? fixed_pix : pix_data_i;
  assign msk_we     = pix_fire & ~col_active;
  assign msk_off    = col - CW'(COLS);
  assign msk_idx    = MIW'(msk_off);

  rbc_bias #(.W(W), .MASKED(MASKED)) u_bias (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .msk_we_i   (msk_we),
    .msk_idx_i  (msk_idx),
    .msk_data_i (pix_data_i),
    .latch_i    (state == ST_BIAS),
    .pix_i      (fix_rdata),
    .bias_o     (bias),
    .fixed_o    (fixed_pix)
  );

  rbc_frame_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .clk_i     (clk_i),
    .we_i      (mem_we),
    .waddr_i   (cell_idx),
    .wdata_i   (mem_wdata),
    .raddr_a_i (cell_idx),
    .rdata_a_o (fix_rdata),
    .raddr_b_i (host_raddr),
    .rdata_b_o (host_rdata)
  );

  rbc_bus #(
    .ADDR_W(ADDR_W), .W(W), .DEPTH(DEPTH),
    .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (bus_addr_i),
    .rd_i        (bus_rd_i),
    .wr_i        (bus_wr_i),
    .wdata_i     (bus_wdata_i),
    .idle_i      (state == ST_IDLE),
    .done_i      (done),
    .mem_rdata_i (host_rdata),
    .mem_raddr_o (host_raddr),
    .start_o     (start),
    .rdata_o     (bus_rdata_o)
  );
endmodule

// File: rtl/row_bias_corr_chk.sv
module row_bias_corr_chk
  import rbc_pkg::*;
#(
  parameter int          COLS      = 64,
  parameter int          MASKED    = 2,
  parameter int          W         = 8,
  parameter int          ADDR_W    = 16,
  parameter int          CW        = 7,
  parameter logic [15:0] CMD_ADDR  = 16'h1000,
  parameter logic [15:0] STAT_ADDR = 16'h1001
) (
  input logic              clk_i,
  input logic              rst_ni,
  input rbc_state_e        state,
  input logic [CW-1:0]     col,
  input logic [W-1:0]      bias,
  input logic [W-1:0]      mem_wdata,
  input logic [W-1:0]      fix_rdata,
  input logic              pix_ready_o,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_rd_i,
  input logic              bus_wr_i,
  input logic [W-1:0]      bus_wdata_i,
  input logic [W-1:0]      bus_rdata_o
);
  AST_START_GET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && bus_wr_i && bus_addr_i == ADDR_W'(CMD_ADDR) && bus_wdata_i[0])
    |=> pix_ready_o); // R2

  AST_COL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col <= CW'(COLS + MASKED)); // R3

  AST_BIAS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FIX && $past(state) == ST_FIX) |-> $stable(bias)); // R4

  AST_SAT_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FIX) |-> (mem_wdata <= fix_rdata)); // R5

  AST_BUSY_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bus_rd_i) && $past(bus_addr_i) == ADDR_W'(STAT_ADDR) && $past(state) != ST_IDLE)
    |-> bus_rdata_o == '0); // R7

  AST_RDATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bus_rd_i) |-> bus_rdata_o == '0); // R8
endmodule

bind row_bias_corr row_bias_corr_chk #(
  .COLS(COLS), .MASKED(MASKED), .W(W), .ADDR_W(ADDR_W), .CW(CW),
  .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state       (state),
  .col         (col),
  .bias        (bias),
  .mem_wdata   (mem_wdata),
  .fix_rdata   (fix_rdata),
  .pix_ready_o (pix_ready_o),
  .bus_addr_i  (bus_addr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o)
);

// File: tb/row_bias_corr_tb.sv
module row_bias_corr_tb;
  localparam int ROWS = 64;
  localparam int COLS = 64;
  localparam int MASKED = 2;
  localparam int LINE = COLS + MASKED;
  localparam int TOTAL = ROWS * LINE;
  localparam logic [15:0] CMD = 16'h1000;
  localparam logic [15:0] STAT = 16'h1001;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pix_valid_i = 1'b0;
  logic [7:0]  pix_data_i = '0;
  logic        pix_ready_o;
  logic [15:0] bus_addr_i = '0;
  logic        bus_rd_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;

  always #10 clk_i = ~clk_i;

  row_bias_corr u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i), .pix_ready_o(pix_ready_o),
    .bus_addr_i(bus_addr_i), .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] px [ROWS][COLS];
  logic [7:0] mk [ROWS][MASKED];

  function automatic logic [7:0] exp_bias(int r);
    int s = 0;
    for (int m = 0; m < MASKED; m++) s += mk[r][m];
    return 8'(s / MASKED);
  endfunction

  function automatic logic [7:0] exp_px(int r, int c);
    logic [7:0] b = exp_bias(r);
    return (px[r][c] > b) ? px[r][c] - b : 8'd0;
  endfunction

  function automatic logic [7:0] stream(int idx);
    int r = idx / LINE;
    int c = idx % LINE;
    return (c < COLS) ? px[r][c] : mk[r][c - COLS];
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_rd_i = 1'b1;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic feed();
    int idx = 0;
    bit fired = 0;
    while (idx < TOTAL) begin
      @(negedge clk_i);
      if (fired) idx++;
      fired = 0;
      if (idx >= TOTAL) break;
      pix_valid_i = ($urandom % 4) != 0;
      pix_data_i = pix_valid_i ? stream(idx) : 8'($urandom); // garbage on gaps, R3
      #1;
      if (pix_valid_i && pix_ready_o) fired = 1;
    end
    pix_valid_i = 1'b0;
  endtask

  task automatic run_frame(string tag);
    logic [7:0] d;
    int n = 0;
    bus_write(CMD, 8'h01);
    chk("R2 ready after start", 16'(pix_ready_o), 16'd1);
    bus_read(STAT, d);
    chk("R2 status cleared", 16'(d), 16'd0);
    bus_write(CMD, 8'h01); // R9 repeated start ignored
    feed();
    d = 8'd0;
    while (d != 8'd1 && n < 20000) begin
      bus_read(STAT, d);
      n++;
    end
    chk("R7 status after frame", 16'(d), 16'd1);
    #1;
    chk("R3 ready low when idle", 16'(pix_ready_o), 16'd0);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        bus_read(16'(r * COLS + c), d);
        chk(tag, 16'(d), 16'(exp_px(r, c)));
      end
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<190000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    chk("R1 ready at reset", 16'(pix_ready_o), 16'd0);
    chk("R1 rdata at reset", 16'(bus_rdata_o), 16'd0);
    rst_ni = 1'b1;
    bus_read(STAT, d);
    chk("R1 status after reset", 16'(d), 16'd0);
    bus_write(CMD, 8'h00);
    chk("R2 bit0 clear no start", 16'(pix_ready_o), 16'd0);

    // frame A: random, per-row bias R5 R6
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) px[r][c] = 8'($urandom);
      for (int m = 0; m < MASKED; m++) mk[r][m] = 8'($urandom % 64);
    end
    run_frame("R5 R6 random pixel");

    // frame B: directed corners R4 R5
    for (int r = 0; r < ROWS; r++) begin
      case (r % 4)
        0: begin mk[r][0] = 8'd0;   mk[r][1] = 8'd0; end
        1: begin mk[r][0] = 8'd255; mk[r][1] = 8'd255; end
        2: begin mk[r][0] = 8'd3;   mk[r][1] = 8'd4; end
        default: begin mk[r][0] = 8'($urandom); mk[r][1] = 8'($urandom); end
      endcase
      for (int c = 0; c < COLS; c++) px[r][c] = 8'($urandom);
      if (r % 4 == 1) px[r][0] = 8'd255;
      if (r % 4 == 2) begin
        case (c_sel(0)) default: ; endcase
        for (int c = 0; c < COLS; c++)
          case (c % 5)
            0: px[r][c] = 8'd0;
            1: px[r][c] = 8'd2;
            2: px[r][c] = 8'd3;
            3: px[r][c] = 8'd4;
            default: px[r][c] = 8'd200;
          endcase
      end
      if (r % 4 == 3) px[r][0] = exp_bias(r);
    end
    chk("R4 odd sum truncates", 16'(exp_bias(2)), 16'd3);
    run_frame("R4 R5 directed pixel");

    // R9 frame-store write ignored
    bus_write(16'd5, ~exp_px(0, 5));
    bus_read(16'd5, d);
    chk("R9 store write ignored", 16'(d), 16'(exp_px(0, 5)));
    // R8 unmapped read and quiet cycle after strobe
    bus_read(16'h2000, d);
    chk("R8 unmapped reads 0", 16'(d), 16'd0);
    bus_read(STAT, d);
    chk("R8 status byte", 16'(d), 16'd1);
    @(negedge clk_i);
    chk("R8 rdata returns to 0", 16'(bus_rdata_o), 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int c_sel(int x);
    return x;
  endfunction
endmodule